// File: doc/BRIEF.md
# Line Loopback Code Detector

This block watches a serial T1 receive bit stream for the two in-band line loopback codes. The activate code is the 5-bit pattern 00001 repeated without a break. The deactivate code is the 3-bit pattern 001 repeated the same way. When one of these codes has held on the line long enough, the block raises the matching status flag. A downstream controller reads the flags and performs the loopback action itself.

Each code is searched for on two paths at once. The unframed path examines every received bit. The framed path skips the bits that the frame-bit marker flags, so a code carried only in the payload, with framing bits interleaved, is still found. A code is declared when either path qualifies.

Each path keeps the last code period of bits and checks every new bit against the bit one period earlier. It tallies these mismatches, together with the count of ones, over fixed blocks of received bits. A block that stays within its limits adds its length to a persistence count, so scattered line errors are tolerated. A block that exceeds them resets the count. The flag rises only once the count reaches the qualification length, which is 74112 bit periods (48 ms at 1.544 Mb/s) by default.

The input is a plain bit stream qualified by `bit_valid`. There is no ready signal and no back-pressure: the block accepts every bit that is presented with `bit_valid` high.

Top module: `loop_code_detector`

## Requirements
- R1: A continuous 00001 stream (one 1 followed by four 0s, repeated) sets `act_det` high once it has held for the qualification length.
- R2: A continuous 001 stream (one 1 followed by two 0s, repeated) sets `deact_det` high once it has held for the qualification length.
- R3: Bits received while `frame_bit` is high are skipped by the framed path. A code carried only in the payload, with arbitrary framing bits inserted between payload bits, is still detected. If the same stream arrives with `frame_bit` held low, it is not detected.
- R4: A flag rises only after QUAL_BITS received bits, counted as whole blocks of BLOCK_LEN bits, have all passed in a row. Before that it stays low.
- R5: A block passes when two conditions both hold: at most MISS_LIMIT of its bits differ from the bit one code period earlier, and its count of ones lies between BLOCK_LEN/P − MISS_LIMIT and BLOCK_LEN/P + 1 + MISS_LIMIT, where P is the code period. As a result, a single bit error in a block is tolerated.
- R6: A flag drops at the end of the first block that fails, and qualification then restarts from zero.
- R7: Cycles with `bit_valid` low have no effect on any counter or flag.
- R8: `act_det` and `deact_det` are never high together.
- R9: A synchronous active-high `rst` clears all counters and both flags. The flags are low on the clock edge that follows a reset cycle.
- R10: A stream that is not one of the two codes, such as all zeros, never raises either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Bit enable: a received bit is present this cycle |
| bit_data | input | 1 | Received line bit |
| frame_bit | input | 1 | Marks the current bit as a framing bit |
| act_det | output | 1 | Activate code detected |
| deact_det | output | 1 | Deactivate code detected |

## Verification
The bench builds the block with BLOCK_LEN=30, MISS_LIMIT=2 and QUAL_BITS=90. With these values a flag qualifies after three passing blocks, or 90 bits, instead of tens of thousands of bits. That makes several things practical in a short run: the exact qualification boundary, a block carrying one tolerated error beside a block carrying too many, and a handover from one code to the other. A 13-bit framing cadence places two or three framing bits in each block. This is enough to make the marker decide whether the framed path sees the code or not.

// File: rtl/llc_pkg.sv
package llc_pkg;
  localparam int NUM_CODES = 2;
  localparam int NUM_PATHS = 2;
  localparam int ACT_PERIOD = 5;
  localparam int DEACT_PERIOD = 3;

  function automatic int code_period(input int code_idx);
    return (code_idx == 0) ? ACT_PERIOD : DEACT_PERIOD;
  endfunction
endpackage

// File: rtl/llc_code_checker.sv
module llc_code_checker #(
  parameter int PERIOD     = 5,
  parameter int BLOCK_LEN  = 1024,
  parameter int MISS_LIMIT = 8,
  parameter int QUAL_BITS  = 74112
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic qualified
);
  localparam int IDX_W   = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int CNT_W   = $clog2(BLOCK_LEN + 1);
  localparam int QW      = $clog2(QUAL_BITS + BLOCK_LEN + 1);
  localparam int ONES_NOM = BLOCK_LEN / PERIOD;
  localparam int ONES_LO  = ONES_NOM - MISS_LIMIT;
  localparam int ONES_HI  = ONES_NOM + 1 + MISS_LIMIT;

  logic [PERIOD-1:0] hist;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  miss_cnt, ones_cnt, miss_tot, ones_tot;
  logic [QW-1:0]     qual_cnt;
  logic              mismatch, blk_end, blk_pass;

  // Periodic prediction: the new bit should equal the bit one period back.
  assign mismatch = bit_in ^ hist[PERIOD-1];
  assign miss_tot = miss_cnt + {{(CNT_W-1){1'b0}}, mismatch};
  assign ones_tot = ones_cnt + {{(CNT_W-1){1'b0}}, bit_in};
  assign blk_end  = bit_en && (bit_idx == IDX_W'(BLOCK_LEN - 1));

  always_comb begin
    blk_pass = (int'(miss_tot) <= MISS_LIMIT) &&
               (int'(ones_tot) >= ONES_LO) &&
               (int'(ones_tot) <= ONES_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      bit_idx   <= '0;
      miss_cnt  <= '0;
      ones_cnt  <= '0;
      qual_cnt  <= '0;
      qualified <= 1'b0;
    end else if (bit_en) begin
      hist <= {hist[PERIOD-2:0], bit_in};
      if (blk_end) begin
        bit_idx  <= '0;
        miss_cnt <= '0;
        ones_cnt <= '0;
        if (blk_pass) begin
          if (int'(qual_cnt) < QUAL_BITS)
            qual_cnt <= qual_cnt + QW'(BLOCK_LEN);
          qualified <= (int'(qual_cnt) + BLOCK_LEN >= QUAL_BITS);
        end else begin
          qual_cnt  <= '0;
          qualified <= 1'b0;
        end
      end else begin
        bit_idx  <= bit_idx + 1'b1;
        miss_cnt <= miss_tot;
        ones_cnt <= ones_tot;
      end
    end
  end

  // R4: qualification can only begin at a block boundary
  assert_rise_at_block_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> $past(blk_end));

  // R6: a failing block clears qualification
  assert_fail_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (blk_end && !blk_pass) |=> !qualified);

  // R7: idle cycles leave the persistence count untouched
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_en) && !$past(rst)) |-> ($stable(qual_cnt) && $stable(qualified)));
endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector #(
  parameter int BLOCK_LEN  = 1024,
  parameter int MISS_LIMIT = 8,
  parameter int QUAL_BITS  = 74112
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic frame_bit,
  output logic act_det,
  output logic deact_det
);
  import llc_pkg::*;

  localparam int N_CHK = NUM_CODES * NUM_PATHS;

  logic [N_CHK-1:0] qual;
  logic act_any, deact_any;

  // Index = code*2 + path; path 0 unframed, path 1 framed.
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      logic en;
      if (p == 0) begin : g_unframed
        assign en = bit_valid;
      end else begin : g_framed
        assign en = bit_valid & ~frame_bit;
      end
      llc_code_checker #(
        .PERIOD    (code_period(c)),
        .BLOCK_LEN (BLOCK_LEN),
        .MISS_LIMIT(MISS_LIMIT),
        .QUAL_BITS (QUAL_BITS)
      ) chk_i (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (en),
        .bit_in   (bit_data),
        .qualified(qual[c*NUM_PATHS + p])
      );
    end
  end

  assign act_any   = |qual[1:0];
  assign deact_any = |qual[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_det   <= 1'b0;
      deact_det <= 1'b0;
    end else begin
      act_det   <= act_any & ~deact_any;
      deact_det <= deact_any & ~act_any;
    end
  end

  // R9: reset clears both flags on the following edge
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!act_det && !deact_det));

  // R8: flags are mutually exclusive
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(act_det && deact_det));

  // R1: activate flag only follows a qualified activate checker
  assert_act_source_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(act_det) |-> $past(act_any));

  // R2: deactivate flag only follows a qualified deactivate checker
  assert_deact_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(deact_det) |-> $past(deact_any));
endmodule

// File: tb/loop_code_detector_tb_top.sv
`timescale 1ns/1ps
module loop_code_detector_tb_top;
  localparam int BLK = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0, bit_data = 1'b0, frame_bit = 1'b0;
  logic act_det, deact_det;
  int checks = 0, failures = 0;
  int ph = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  loop_code_detector #(.BLOCK_LEN(BLK), .MISS_LIMIT(2), .QUAL_BITS(90)) dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .frame_bit(frame_bit), .act_det(act_det), .deact_det(deact_det));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_data  = ~bit_data;
      frame_bit = i[0];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0;
    idle(3);
    rst = 1'b0;
    ph = 0;
  endtask

  // Sends nbits line bits: code of the given period, flips per 30-bit block
  // (1: position 10; 3: positions 2, 12, 22), optional framing bits.
  task automatic send(input int period, input int nbits, input int flips,
                      input int frame_every, input logic mark);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      if (frame_every > 0 && (i % frame_every) == frame_every - 1) begin
        bit_data = 1'b1; frame_bit = mark;
      end else begin
        bit_data  = ((ph % period) == period - 1);
        frame_bit = 1'b0;
        ph++;
        if ((flips == 1 && (i % BLK) == 10) ||
            (flips == 3 && ((i % BLK) % 10) == 2))
          bit_data = ~bit_data;
      end
    end
    idle(3);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9 act after reset", act_det, 1'b0);
    check("R9 deact after reset", deact_det, 1'b0);
  endtask

  task automatic t_activate();
    do_reset();
    send(5, 60, 0, 0, 1'b0);
    check("R4 act low before qualification", act_det, 1'b0);
    send(5, 30, 0, 0, 1'b0);
    check("R1 act detected", act_det, 1'b1);
    check("R8 deact low while act", deact_det, 1'b0);
    idle(50);
    check("R7 idle cycles ignored", act_det, 1'b1);
  endtask

  task automatic t_handover();
    ph = 0;
    send(3, 30, 0, 0, 1'b0);
    check("R6 act drops on failing block", act_det, 1'b0);
    send(3, 90, 0, 0, 1'b0);
    check("R2 deact detected", deact_det, 1'b1);
    check("R8 act low while deact", act_det, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 mid-run reset clears deact", deact_det, 1'b0);
  endtask

  task automatic t_errors();
    do_reset();
    send(5, 30, 0, 0, 1'b0);
    send(5, 90, 1, 0, 1'b0);
    check("R5 one error per block tolerated", act_det, 1'b1);
    send(5, 30, 3, 0, 1'b0);
    check("R5 excess errors fail block", act_det, 1'b0);
  endtask

  task automatic t_zeros();
    do_reset();
    for (int i = 0; i < 150; i++) begin
      @(negedge clk); bit_valid = 1'b1; bit_data = 1'b0; frame_bit = 1'b0;
    end
    idle(3);
    check("R10 zeros no act", act_det, 1'b0);
    check("R10 zeros no deact", deact_det, 1'b0);
  endtask

  task automatic t_framed();
    do_reset();
    send(5, 130, 0, 13, 1'b1);
    check("R3 framed act detected", act_det, 1'b1);
    do_reset();
    send(5, 130, 0, 13, 1'b0);
    check("R3 unmarked framing bits break code", act_det, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_activate();
    t_handover();
    t_errors();
    t_zeros();
    t_framed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule